// File: doc/BRIEF.md
# I/O Address Window Decoder

This block sits on the inbound side of an I/O adapter and decides, for every transaction seen on a 40-bit system bus, whether it belongs to the downstream I/O bus. It checks each address against two programmable windows in parallel. When an address falls in a window and the current mode allows it, the block raises a forward strobe one cycle later. With that strobe it gives the index of the window that hit and the 32-bit address to place on the downstream bus.

Bits are described here most-significant-first in the usual little-endian vector notation. An address is a candidate only if its top eight bits `txn_addr[39:32]` are all ones. Its 4-bit segment `txn_addr[31:28]` must equal the window's programmed segment. Its 12-bit range field `txn_addr[27:16]` must lie in the half-open interval [low, high) programmed for that window. `txn_addr[15:0]` takes no part in matching. Each window holds a LOW word, whose bits [15:12] are the segment and bits [11:0] are the low range bound, and a HIGH word, whose bits [11:0] are the high range bound. Both words are loaded through a one-cycle write strobe.

The transaction input is a plain strobe with no back-pressure. The block accepts one transaction in every cycle, and whatever receives the forward strobe must take it in the cycle it appears. The mode pin is a static control input. Mode 1 forwards matching traffic as is. Mode 3 forwards only matching short writes and redirects them to broadcast space. Modes 0 and 2 forward nothing.

Top module: `aw_io_window_dec`

## Requirements
- R1: A transaction whose `txn_addr[39:32]` is not 8'hFF is never forwarded.
- R2: A window hits only if `txn_addr[31:28]` equals bits [15:12] of that window's LOW word.
- R3: A window hits only if LOW[11:0] <= `txn_addr[27:16]` < HIGH[11:0]. The low bound is inclusive and the high bound is exclusive. `txn_addr[15:0]` does not affect the hit decision.
- R4: A window whose LOW[11:0] is greater than or equal to its HIGH[11:0] never hits.
- R5: When both windows hit, `fwd_win` is 0. When only window 1 hits, `fwd_win` is 1.
- R6: In mode 1, a forwarded address is {4'hF, `txn_addr[27:2]`, 2'b00}, and both plain and short-write transactions are forwarded.
- R7: In mode 0 and in the reserved mode 2, no transaction is forwarded.
- R8: In mode 3, only transactions with `txn_short_wr`=1 are forwarded. Their address is the R6 address with bits [31:18] forced to ones.
- R9: `fwd_valid`, `fwd_win` and `fwd_addr` update on the clock edge that samples `txn_valid`. In any cycle without a forward, `fwd_win` and `fwd_addr` are zero. With `txn_valid` low, nothing is forwarded.
- R10: A bound write is used by a transaction in the next cycle. A transaction in the same cycle as the write is still checked against the old bounds. `cfg_hi`=0 selects the LOW word and `cfg_hi`=1 selects the HIGH word.
- R11: Reset clears all bounds to zero, so no window hits, and clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 off, 1 include, 2 reserved (off), 3 peek |
| cfg_we | input | 1 | Bound register write strobe |
| cfg_win | input | 1 | Window selected for the write |
| cfg_hi | input | 1 | 0 writes the LOW word, 1 writes the HIGH word |
| cfg_wdata | input | 32 | Bound write data |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_addr | input | 40 | Transaction address |
| txn_short_wr | input | 1 | Transaction is a short write |
| fwd_valid | output | 1 | Transaction is forwarded downstream |
| fwd_win | output | 1 | Index of the window that hit |
| fwd_addr | output | 32 | Downstream address |

## Verification
The bench builds the block with its defaults: a 40-bit address, two windows, an 8-bit prefix, a 4-bit segment, a 12-bit range field and 14 broadcast bits. With two windows, overlapping windows can be set up to test priority, one window can be emptied while the other stays live, and each side of both range bounds can be reached directly. The 12-bit range lets the directed tests hit exact bound values, and a random phase then mixes modes, short writes and near-miss prefixes.

// File: rtl/aw_pkg.sv
package aw_pkg;
  typedef enum logic [1:0] {
    AW_OFF  = 2'd0,
    AW_INCL = 2'd1,
    AW_RSVD = 2'd2,
    AW_PEEK = 2'd3
  } aw_mode_e;
endpackage

// File: rtl/aw_bound_regs.sv
module aw_bound_regs #(
  parameter int NWIN  = 2,
  parameter int IDX_W = 1,
  parameter int REG_W = 32,
  parameter int SEG_W = 4,
  parameter int RNG_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           win,
  input  logic                       sel_hi,
  input  logic [REG_W-1:0]           wdata,
  output logic [NWIN-1:0][SEG_W-1:0] seg,
  output logic [NWIN-1:0][RNG_W-1:0] lo_rng,
  output logic [NWIN-1:0][RNG_W-1:0] hi_rng
);
  localparam int FIELD_W = SEG_W + RNG_W;

  logic unused_wdata;
  assign unused_wdata = ^wdata[REG_W-1:FIELD_W];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg[w]    <= '0;
        lo_rng[w] <= '0;
        hi_rng[w] <= '0;
      end else if (we && (win == IDX_W'(w))) begin
        if (sel_hi) begin
          hi_rng[w] <= wdata[RNG_W-1:0];
        end else begin
          seg[w]    <= wdata[FIELD_W-1:RNG_W];
          lo_rng[w] <= wdata[RNG_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/aw_win_match.sv
module aw_win_match #(
  parameter int PFX_W = 8,
  parameter int SEG_W = 4,
  parameter int RNG_W = 12
) (
  input  logic [PFX_W-1:0] pfx,
  input  logic [SEG_W-1:0] addr_seg,
  input  logic [RNG_W-1:0] addr_rng,
  input  logic [SEG_W-1:0] win_seg,
  input  logic [RNG_W-1:0] win_lo,
  input  logic [RNG_W-1:0] win_hi,
  output logic             hit
);
  logic pfx_ok, seg_ok, above_lo, below_hi;

  always_comb begin
    pfx_ok   = &pfx;
    seg_ok   = (addr_seg == win_seg);
    above_lo = (addr_rng >= win_lo);
    below_hi = (addr_rng < win_hi);
    hit      = pfx_ok && seg_ok && above_lo && below_hi;
  end
endmodule

// File: rtl/aw_remap.sv
module aw_remap #(
  parameter int OUT_W   = 32,
  parameter int ONES_W  = 4,
  parameter int ZERO_W  = 2,
  parameter int BCAST_W = 14,
  localparam int CARRY_W = OUT_W - ONES_W - ZERO_W
) (
  input  logic [CARRY_W-1:0] carry,
  input  logic               peek,
  output logic [OUT_W-1:0]   out
);
  localparam logic [OUT_W-1:0] BCAST_MASK =
    {{BCAST_W{1'b1}}, {(OUT_W-BCAST_W){1'b0}}};

  logic [OUT_W-1:0] base;

  always_comb begin
    base = {{ONES_W{1'b1}}, carry, {ZERO_W{1'b0}}};
    out  = peek ? (base | BCAST_MASK) : base;
  end
endmodule

// File: rtl/aw_io_window_dec.sv
module aw_io_window_dec #(
  parameter int ADDR_W  = 40,
  parameter int OUT_W   = 32,
  parameter int REG_W   = 32,
  parameter int PFX_W   = 8,
  parameter int SEG_W   = 4,
  parameter int RNG_W   = 12,
  parameter int NWIN    = 2,
  parameter int ONES_W  = 4,
  parameter int ZERO_W  = 2,
  parameter int BCAST_W = 14,
  localparam int IDX_W  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_win,
  input  logic              cfg_hi,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              txn_valid,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              txn_short_wr,
  output logic              fwd_valid,
  output logic [IDX_W-1:0]  fwd_win,
  output logic [OUT_W-1:0]  fwd_addr
);
  import aw_pkg::*;

  localparam int PFX_LSB = ADDR_W - PFX_W;
  localparam int SEG_LSB = PFX_LSB - SEG_W;
  localparam int RNG_LSB = SEG_LSB - RNG_W;
  localparam int CARRY_W = OUT_W - ONES_W - ZERO_W;
  localparam int CARRY_LSB = SEG_LSB - CARRY_W;

  logic [NWIN-1:0][SEG_W-1:0] w_seg;
  logic [NWIN-1:0][RNG_W-1:0] w_lo, w_hi;
  logic [NWIN-1:0]            hit;
  logic [IDX_W-1:0]           hit_idx;
  logic                       any_hit, go, peek;
  logic [OUT_W-1:0]           remapped;
  aw_mode_e                   mode_e;

  logic unused_addr;
  if (CARRY_LSB > 0) begin : g_unused
    assign unused_addr = ^txn_addr[CARRY_LSB-1:0];
  end else begin : g_nounused
    assign unused_addr = 1'b0;
  end

  aw_bound_regs #(
    .NWIN(NWIN), .IDX_W(IDX_W), .REG_W(REG_W), .SEG_W(SEG_W), .RNG_W(RNG_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .win(cfg_win), .sel_hi(cfg_hi),
    .wdata(cfg_wdata), .seg(w_seg), .lo_rng(w_lo), .hi_rng(w_hi)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_match
    aw_win_match #(.PFX_W(PFX_W), .SEG_W(SEG_W), .RNG_W(RNG_W)) i_match (
      .pfx(txn_addr[ADDR_W-1:PFX_LSB]),
      .addr_seg(txn_addr[PFX_LSB-1:SEG_LSB]),
      .addr_rng(txn_addr[SEG_LSB-1:RNG_LSB]),
      .win_seg(w_seg[w]), .win_lo(w_lo[w]), .win_hi(w_hi[w]),
      .hit(hit[w])
    );
  end

  always_comb begin
    hit_idx = '0;
    any_hit = 1'b0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  assign mode_e = aw_mode_e'(mode);
  assign peek   = (mode_e == AW_PEEK);

  always_comb begin
    case (mode_e)
      AW_INCL: go = txn_valid && any_hit;
      AW_PEEK: go = txn_valid && any_hit && txn_short_wr;
      default: go = 1'b0;
    endcase
  end

  aw_remap #(
    .OUT_W(OUT_W), .ONES_W(ONES_W), .ZERO_W(ZERO_W), .BCAST_W(BCAST_W)
  ) i_remap (
    .carry(txn_addr[SEG_LSB-1:CARRY_LSB]), .peek(peek), .out(remapped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_win   <= '0;
      fwd_addr  <= '0;
    end else begin
      fwd_valid <= go;
      fwd_win   <= go ? hit_idx : '0;
      fwd_addr  <= go ? remapped : '0;
    end
  end
endmodule

// File: rtl/aw_io_window_dec_chk.sv
module aw_io_window_dec_chk #(
  parameter int PFX_W   = 8,
  parameter int OUT_W   = 32,
  parameter int IDX_W   = 1,
  parameter int ONES_W  = 4,
  parameter int ZERO_W  = 2,
  parameter int BCAST_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             txn_valid,
  input logic [PFX_W-1:0] txn_pfx,
  input logic             txn_short_wr,
  input logic             fwd_valid,
  input logic [IDX_W-1:0] fwd_win,
  input logic [OUT_W-1:0] fwd_addr
);
  assert_bad_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !(&txn_pfx)) |=> !fwd_valid);

  assert_fixed_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> ((&fwd_addr[OUT_W-1 -: ONES_W]) && (fwd_addr[ZERO_W-1:0] == '0)));

  assert_off_modes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !mode[0]) |=> !fwd_valid);

  assert_peek_long_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && (mode == 2'd3) && !txn_short_wr) |=> !fwd_valid);

  assert_peek_bcast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && (mode == 2'd3)) |=> (!fwd_valid || (&fwd_addr[OUT_W-1 -: BCAST_W])));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |=> !fwd_valid);

  assert_quiet_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_valid |-> ((fwd_addr == '0) && (fwd_win == '0)));
endmodule

bind aw_io_window_dec aw_io_window_dec_chk #(
  .PFX_W(PFX_W), .OUT_W(OUT_W), .IDX_W(IDX_W),
  .ONES_W(ONES_W), .ZERO_W(ZERO_W), .BCAST_W(BCAST_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .txn_valid(txn_valid),
  .txn_pfx(txn_addr[ADDR_W-1 -: PFX_W]), .txn_short_wr(txn_short_wr),
  .fwd_valid(fwd_valid), .fwd_win(fwd_win), .fwd_addr(fwd_addr)
);

// File: tb/test_aw_io_window_dec.sv
`timescale 1ns/1ps
module test_aw_io_window_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_win = 1'b0;
  logic        cfg_hi = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        txn_valid = 1'b0;
  logic [39:0] txn_addr = '0;
  logic        txn_short_wr = 1'b0;
  logic        fwd_valid;
  logic [0:0]  fwd_win;
  logic [31:0] fwd_addr;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R11";

  int unsigned m_seg[2], m_lo[2], m_hi[2];
  logic        exp_v = 1'b0;
  logic [0:0]  exp_w = 1'b0;
  logic [31:0] exp_a = '0;

  always #2.5 clk = ~clk;

  aw_io_window_dec i_aw_io_window_dec (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata), .txn_valid(txn_valid),
    .txn_addr(txn_addr), .txn_short_wr(txn_short_wr),
    .fwd_valid(fwd_valid), .fwd_win(fwd_win), .fwd_addr(fwd_addr)
  );

  // Reference model: next outputs from current inputs and current model bounds.
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v = 0; exp_w = 0; exp_a = 0;
      for (int w = 0; w < 2; w++) begin m_seg[w] = 0; m_lo[w] = 0; m_hi[w] = 0; end
    end else begin
      int unsigned rng, seg;
      int sel;
      bit allow;
      rng = int'(txn_addr[27:16]);
      seg = int'(txn_addr[31:28]);
      sel = -1;
      for (int w = 1; w >= 0; w--)
        if (txn_addr[39:32] == 8'hFF && seg == m_seg[w] && rng >= m_lo[w] && rng < m_hi[w])
          sel = w;
      allow = (mode == 2'd1) || (mode == 2'd3 && txn_short_wr);
      if (txn_valid && allow && sel >= 0) begin
        exp_v = 1;
        exp_w = sel[0:0];
        exp_a = {4'hF, txn_addr[27:2], 2'b00};
        if (mode == 2'd3) exp_a = exp_a | 32'hFFFC_0000;
      end else begin
        exp_v = 0; exp_w = 0; exp_a = 0;
      end
      if (cfg_we) begin
        if (cfg_hi) m_hi[cfg_win] = cfg_wdata[11:0];
        else begin m_seg[cfg_win] = cfg_wdata[15:12]; m_lo[cfg_win] = cfg_wdata[11:0]; end
      end
    end
    cmp_on = 1;
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      tests++;
      if (fwd_valid !== exp_v || fwd_win !== exp_w || fwd_addr !== exp_a) begin
        fails++;
        $display("FAIL %s: got v=%0b w=%0d a=%h, expected v=%0b w=%0d a=%h",
                 cur_req, fwd_valid, fwd_win, fwd_addr, exp_v, exp_w, exp_a);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    cfg_we = 0; txn_valid = 0; txn_short_wr = 0;
  endtask

  task automatic wr(input bit win, input bit hi, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_win = win; cfg_hi = hi; cfg_wdata = d; txn_valid = 0;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic txn(input logic [7:0] pfx, input logic [3:0] seg,
                     input logic [11:0] rng, input logic [15:0] low, input bit sw);
    @(negedge clk);
    cfg_we = 0; txn_valid = 1; txn_short_wr = sw; txn_addr = {pfx, seg, rng, low};
  endtask

  initial begin
    // R11: reset state
    repeat (2) @(negedge clk);
    tests++;
    if (fwd_valid !== 0 || fwd_win !== 0 || fwd_addr !== 0) begin
      fails++;
      $display("FAIL R11: got v=%0b w=%0d a=%h, expected 0 0 0", fwd_valid, fwd_win, fwd_addr);
    end
    rst_n = 1;
    mode = 2'd1;
    cur_req = "R11"; txn(8'hFF, 4'h0, 12'h000, 16'h0000, 0); idle();

    wr(0, 0, 32'h0000_3100); wr(0, 1, 32'h0000_0200);
    wr(1, 0, 32'h0000_5050); wr(1, 1, 32'h0000_0080);

    cur_req = "R6";  txn(8'hFF, 4'h3, 12'h150, 16'hABCD, 0); txn(8'hFF, 4'h3, 12'h150, 16'h1237, 1);
    cur_req = "R1";  txn(8'hFE, 4'h3, 12'h150, 16'h0000, 0); txn(8'h7F, 4'h5, 12'h060, 16'h0000, 0);
    cur_req = "R2";  txn(8'hFF, 4'h4, 12'h150, 16'h0000, 0); txn(8'hFF, 4'h5, 12'h150, 16'h0000, 0);
    cur_req = "R3";  txn(8'hFF, 4'h3, 12'h100, 16'hFFFF, 0); txn(8'hFF, 4'h3, 12'h1FF, 16'h0000, 0);
                     txn(8'hFF, 4'h3, 12'h200, 16'h0000, 0); txn(8'hFF, 4'h3, 12'h0FF, 16'hFFFF, 0);
    cur_req = "R5";  txn(8'hFF, 4'h5, 12'h060, 16'h4444, 0);
    cur_req = "R9";  @(negedge clk); txn_valid = 0; txn_addr = {8'hFF, 4'h3, 12'h150, 16'h0}; idle();

    wr(1, 0, 32'h0000_3180); wr(1, 1, 32'h0000_0300);
    cur_req = "R5";  txn(8'hFF, 4'h3, 12'h190, 16'h0000, 0); txn(8'hFF, 4'h3, 12'h250, 16'h0000, 0);
                     txn(8'hFF, 4'h3, 12'h120, 16'h0000, 0);
    idle();
    wr(0, 0, 32'h0000_3200);
    cur_req = "R4";  txn(8'hFF, 4'h3, 12'h200, 16'h0000, 0); txn(8'hFF, 4'h3, 12'h1F0, 16'h0000, 0);
    idle();
    wr(1, 0, 32'h0000_3300); wr(1, 1, 32'h0000_0100);
    cur_req = "R4";  txn(8'hFF, 4'h3, 12'h300, 16'h0000, 0); txn(8'hFF, 4'h3, 12'h0FF, 16'h0000, 0);
    idle();

    // R10: write and transaction in the same cycle, then the next cycle
    cur_req = "R10";
    @(negedge clk);
    cfg_we = 1; cfg_win = 0; cfg_hi = 0; cfg_wdata = 32'h0000_3010;
    txn_valid = 1; txn_short_wr = 0; txn_addr = {8'hFF, 4'h3, 12'h020, 16'h0};
    @(negedge clk);
    cfg_we = 0;
    @(negedge clk);
    cfg_we = 1; cfg_win = 0; cfg_hi = 1; cfg_wdata = 32'h0000_0400;
    @(negedge clk);
    cfg_we = 0;
    idle();

    cur_req = "R7";  mode = 2'd0; txn(8'hFF, 4'h3, 12'h020, 16'h0000, 0); txn(8'hFF, 4'h3, 12'h020, 16'h0000, 1);
                     mode = 2'd2; txn(8'hFF, 4'h3, 12'h020, 16'h0000, 0); txn(8'hFF, 4'h3, 12'h020, 16'h0000, 1);
    cur_req = "R8";  mode = 2'd3; txn(8'hFF, 4'h3, 12'h020, 16'h5555, 1); txn(8'hFF, 4'h3, 12'h020, 16'h5555, 0);
                     txn(8'hFF, 4'h3, 12'h3FF, 16'hFFFF, 1);
    idle();

    cur_req = "R6/R8 random";
    for (int i = 0; i < 400; i++) begin
      logic [7:0] p;
      p = ($urandom_range(0, 4) == 0) ? 8'(($urandom & 8'hFF)) : 8'hFF;
      mode = 2'($urandom);
      txn(p, 4'($urandom_range(2, 4)), 12'($urandom_range(0, 12'h500)), 16'($urandom), bit'($urandom));
      if ($urandom_range(0, 3) == 0) txn_valid = 0;
    end
    idle(); idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule